// File: doc/BRIEF.md
# Multi-Role Reset/GPIO Pin Controller

This block governs one external pin that serves one of three roles: an active-low reset input, a general-purpose logic input, or an open-drain logic output. A three-bit role register decides the role. The register sits at bus address 0x80 and is written and read over a simple register bus with an address, write data, a write strobe and combinational read data.

The pin input passes through a two-flop synchroniser before it is used. The synchronised level is used for reset detection and for read-back. The block drives an output-enable for an external open-drain pad: when that enable is high, the pad pulls the pin low.

The internal reset request is derived from the pin, but it never clears the role register. Only the power-on reset does that, so a reset raised through the pin cannot turn itself back on.

Top module: `pin_role_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) the role register reads 0x00 at address 0x80, `pin_drive_low` is 0, and `pin_level` is 1.
- R2: A write with `bus_we` high and `bus_addr` equal to 0x80 stores `bus_wdata[2:0]`. Bits 7:3 of the write data are ignored and always read back as 0. The field layout is: bit 0 enables GPIO, bit 1 selects direction (1 is output), and bit 2 is the data bit.
- R3: A write to any other address leaves the role register unchanged.
- R4: While bit 0 is 0 (reset role), `reset_req` is 1 exactly when the synchronised pin level is 0.
- R5: While bit 0 is 1, `reset_req` stays 0 whatever the pin does.
- R6: In input role (bit 0 = 1, bit 1 = 0), read bit 2 returns the synchronised pin level.
- R7: In output role (bits 0 and 1 both 1), `pin_drive_low` equals the inverse of the stored bit 2, and read bit 2 returns the stored value rather than the pin.
- R8: In reset role and in input role, `pin_drive_low` is 0 whatever the stored bit 2 holds. In reset role, read bit 2 returns the stored value.
- R9: An asserted `reset_req` does not alter the role register. Only `rst_n` returns it to 0x00.
- R10: Reads at any address other than 0x80 return 0.
- R11: `pin_level` follows `pin_in` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 1 | Raw level seen on the pin |
| pin_drive_low | output | 1 | Open-drain enable: 1 pulls the pin low |
| pin_level | output | 1 | Synchronised pin level |
| reset_req | output | 1 | Internal reset request raised by the pin |

## Verification
The hardest case to reach is a pin-driven reset request firing while the register holds non-zero direction and data bits. This is the only situation in which a faulty design could let the request clear the register, and it is invisible unless the register is read back afterwards. The stimulus writes 0x06, which keeps bit 0 at 0 while setting the other two bits. It then holds the pin low long enough for `reset_req` to assert and reads the register while the request is still active. Only after that does it apply `rst_n` to show that the power-on reset alone clears the register.

// File: rtl/pin_role_pkg.sv
// Shared types for the reset/GPIO pin controller.
// Assumes the role field occupies bits [2:0] of the register word.
package pin_role_pkg;
    typedef struct packed {
        logic data;   // bit 2: read-back or drive value
        logic dir;    // bit 1: 1 = output
        logic en;     // bit 0: 1 = GPIO, 0 = reset input
    } role_t;

    localparam int ROLE_W = $bits(role_t);
endpackage

// File: rtl/pin_sync.sv
// Multi-flop synchroniser for the asynchronous pin level.
// Assumes STAGES >= 2; resets to RESET_VAL (idle-high pin).
module pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shift_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= {STAGES{RESET_VAL}};
        else        shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];
endmodule

// File: rtl/pin_role_reg.sv
// Role register: captures the low role bits on a write hit.
// Cleared only by the power-on reset input, never by the pin request.
module pin_role_reg
    import pin_role_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output role_t             role_q
);
    logic hit;
    assign hit = we && (addr == REG_ADDR);

    // Store the role field on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n)   role_q <= '0;
        else if (hit) role_q <= role_t'(wdata[ROLE_W-1:0]);
    end
endmodule

// File: rtl/pin_role_decode.sv
// Combinational decode of role bits into pad enable, reset request
// and read data. Assumes pin_level is already synchronised.
module pin_role_decode
    import pin_role_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h80
) (
    input  role_t             role,
    input  logic              pin_level,
    input  logic [ADDR_W-1:0] addr,
    output logic              drive_low,
    output logic              reset_req,
    output logic [DATA_W-1:0] rdata
);
    logic input_role;
    logic output_role;
    logic bit2_rd;

    assign input_role  = role.en && !role.dir;
    assign output_role = role.en &&  role.dir;

    // Drive and request outputs from the current role.
    always_comb begin
        drive_low = output_role && !role.data;
        reset_req = !role.en && !pin_level;
    end

    // Read mux: bit 2 shows the pin in input role, else the stored bit.
    always_comb begin
        bit2_rd = input_role ? pin_level : role.data;
        rdata   = '0;
        if (addr == REG_ADDR) rdata[ROLE_W-1:0] = {bit2_rd, role.dir, role.en};
    end
endmodule

// File: rtl/pin_role_ctrl.sv
// Top of the reset/GPIO pin controller: synchroniser, role register
// and decode. Assumes an external open-drain pad driven by pin_drive_low.
module pin_role_ctrl
    import pin_role_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h80,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pin_in,
    output logic              pin_drive_low,
    output logic              pin_level,
    output logic              reset_req
);
    role_t role_q;

    pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_level)
    );

    pin_role_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .role_q(role_q)
    );

    pin_role_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_dec (
        .role(role_q), .pin_level(pin_level), .addr(bus_addr),
        .drive_low(pin_drive_low), .reset_req(reset_req), .rdata(bus_rdata)
    );
endmodule

// File: rtl/pin_role_ctrl_chk.sv
// Property checker for pin_role_ctrl, bound into every instance.
// Assumes the default two-stage synchroniser and 8-bit bus.
module pin_role_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_we,
    input logic       pin_in,
    input logic       pin_level,
    input logic       pin_drive_low,
    input logic       reset_req,
    input logic [2:0] role_q
);
    logic [1:0] since_rst;

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h80) |=> (role_q == $past(bus_wdata[2:0])));

    a_r3_other_addr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != 8'h80) |=> $stable(role_q));

    a_r5_no_req_in_gpio: assert property (@(posedge clk) disable iff (!rst_n)
        role_q[0] |-> !reset_req);

    a_r8_no_drive_unless_output: assert property (@(posedge clk) disable iff (!rst_n)
        !(role_q[0] && role_q[1]) |-> !pin_drive_low);

    a_r9_req_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !bus_we) |=> $stable(role_q));

    a_r11_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (pin_level == $past(pin_in, 2)));
endmodule

bind pin_role_ctrl pin_role_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .pin_in(pin_in), .pin_level(pin_level),
    .pin_drive_low(pin_drive_low), .reset_req(reset_req), .role_q(role_q)
);

// File: tb/pin_role_ctrl_bench.sv
// Self-checking bench: vector table walk, then directed reset/corner tests.
module pin_role_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       pin_in = 1'b1;
    logic       pin_drive_low;
    logic       pin_level;
    logic       reset_req;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pin_role_ctrl u_pin_role_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_drive_low(pin_drive_low), .pin_level(pin_level), .reset_req(reset_req)
    );

    // Vector: {req_no[3:0], waddr[7:0], wdata[7:0], pin, exp_rd[7:0], exp_drv, exp_req}
    localparam int NV = 9;
    localparam logic [30:0] VEC [NV] = '{
        {4'd4,  8'h80, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0}, // R4 reset role, pin high
        {4'd4,  8'h80, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1}, // R4 reset role, pin low
        {4'd5,  8'h80, 8'h01, 1'b0, 8'h01, 1'b0, 1'b0}, // R5 / R6 input, pin low
        {4'd6,  8'h80, 8'h01, 1'b1, 8'h05, 1'b0, 1'b0}, // R6 input, pin high
        {4'd2,  8'h80, 8'hFB, 1'b1, 8'h03, 1'b1, 1'b0}, // R2 / R7 upper bits dropped, drive low
        {4'd7,  8'h80, 8'h07, 1'b0, 8'h07, 1'b0, 1'b0}, // R7 released, reads stored bit
        {4'd8,  8'h80, 8'h04, 1'b1, 8'h04, 1'b0, 1'b0}, // R8 reset role, data 1 stored
        {4'd8,  8'h80, 8'h05, 1'b0, 8'h01, 1'b0, 1'b0}, // R8 input role never drives
        {4'd3,  8'h81, 8'h03, 1'b1, 8'h05, 1'b0, 1'b0}  // R3 write elsewhere ignored
    };

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h80;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_addr = 8'h80;
        #1;
        // R1 power-on state
        check("R1", "rdata", bus_rdata, 8'h00);
        check("R1", "drive", {7'd0, pin_drive_low}, 8'h00);
        check("R1", "level", {7'd0, pin_level}, 8'h01);
        check("R1", "req", {7'd0, reset_req}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][30:27]);
            wr(VEC[i][26:19], VEC[i][18:11]);
            pin_in = VEC[i][10];
            settle();
            bus_addr = 8'h80;
            #1;
            check(tag, "rdata", bus_rdata, VEC[i][9:2]);
            check(tag, "drive", {7'd0, pin_drive_low}, {7'd0, VEC[i][1]});
            check(tag, "req", {7'd0, reset_req}, {7'd0, VEC[i][0]});
        end

        // R10 other read address returns zero
        wr(8'h80, 8'h07);
        @(negedge clk);
        bus_addr = 8'h10;
        #1;
        check("R10", "rdata", bus_rdata, 8'h00);

        // R11 two-edge synchroniser latency
        pin_in = 1'b1;
        settle();
        @(negedge clk);
        pin_in = 1'b0;
        @(negedge clk);
        check("R11", "level after 1 edge", {7'd0, pin_level}, 8'h01);
        @(negedge clk);
        check("R11", "level after 2 edges", {7'd0, pin_level}, 8'h00);

        // R9 pin reset request keeps register; only rst_n clears
        pin_in = 1'b1;
        wr(8'h80, 8'h06);
        pin_in = 1'b0;
        settle();
        #1;
        check("R9", "req", {7'd0, reset_req}, 8'h01);
        check("R9", "rdata during req", bus_rdata, 8'h06);
        pin_in = 1'b1;
        settle();
        check("R9", "rdata after req", bus_rdata, 8'h06);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9", "rdata after rst_n", bus_rdata, 8'h00);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule